// File: doc/BRIEF.md
# SD Command Frame Transmitter

This block sends one host-to-card command on the single-bit command line of an SD bus. A controller presents a 6-bit command index and a 32-bit argument and raises `start` for one cycle. The block takes them only while `busy` is low. It then shifts out a 48-bit frame, most significant bit first, moving one bit for each cycle in which the bit-rate strobe `bit_en` is high. The 7-bit check code is computed serially as the header and argument bits leave the block. It is then appended to the frame, followed by a closing 1.

The line is driven only while a frame is on the wire. At all other times `cmd_oe` is low and `cmd_out` rests at 1, so the pad and its pull-up keep the line high. A one-cycle `done` pulse marks the moment the line is released, and the controller may start the next command in that same cycle. The strobe comes from an external SD clock divider, so the block never has to know the bus frequency.

Top module: `sd_cmd_tx`

## Requirements
- R1: The frame goes out in this order, with each field sent MSB first: a 0, a 1, the index bits idx[5] down to idx[0], the argument bits arg[31] down to arg[0], the check bits crc[6] down to crc[0], and finally a 1. That is 48 bits in total.
- R2: The check code is CRC7 with generator x^7 + x^3 + 1 (feedback mask 7'b0001001). It starts from zero for each frame and covers only the first 40 frame bits. Index 0 with argument 0 gives 7'b1001010. Index 8 with argument 32'h000001AA gives 7'b1000011. Index 55 with argument 0 gives 7'b0110010.
- R3: `cmd_out` and `cmd_oe` change only at a clock edge where `bit_en` is high, and each such edge advances by exactly one bit. Frame bit 0 appears at the first strobed edge after the edge that accepts `start`.
- R4: `start` is accepted at an edge where `busy` is low, and `busy` is high from the next cycle. A `start` seen while `busy` is high has no effect: neither the frame in flight nor the idle state after it changes.
- R5: `cmd_oe` is high from frame bit 0 through the end bit. While `busy` is low, `cmd_oe` is 0 and `cmd_out` is 1.
- R6: At the strobed edge that follows the end bit, `cmd_oe` falls, `busy` falls and `done` rises. `done` is high for exactly one cycle.
- R7: Reset, including a reset in the middle of a frame, leaves `cmd_out`=1, `cmd_oe`=0, `busy`=0 and `done`=0.
- R8: After `start` is accepted and until the first strobe arrives, the line stays released (`cmd_oe`=0, `cmd_out`=1) while `busy` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per SD bit period |
| start | input | 1 | Request to send one command |
| cmd_idx | input | 6 | Command index, sampled with start |
| cmd_arg | input | 32 | Command argument, sampled with start |
| busy | output | 1 | A command is being sent |
| done | output | 1 | One-cycle pulse when the line is released |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |

## Verification
The bench builds the block with its default parameters: a 6-bit index, a 32-bit argument and a 7-bit code with mask 7'b0001001. This gives the exact 48-bit layout of the bus, so the three known check codes can be compared directly against captured frames. Frames are captured with the strobe high on every cycle, on every third cycle and on every fifth cycle. This makes bit hold between strobes, the release edge and the done pulse visible under different spacings. Directed cases cover a start issued mid-frame, a strobe held off after start, and a reset in the middle of a frame.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_CRC,
        ST_STOP,
        ST_TAIL
    } tx_state_e;

endpackage

// File: rtl/sd_cmd_shreg.sv
module sd_cmd_shreg #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d = load_val;
        end else if (shift) begin
            sh_d = {sh_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign msb = sh_q[W-1];
endmodule

// File: rtl/sd_crc7_ser.sv
module sd_crc7_ser #(
    parameter int               CRC_W = 7,
    parameter logic [CRC_W-1:0] POLY  = 7'b0001001
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic din,
    input  logic drain,
    output logic msb
);
    logic [CRC_W-1:0] crc_d, crc_q;
    logic             fb;

    always_comb begin
        fb    = crc_q[CRC_W-1] ^ din;
        crc_d = crc_q;
        if (clear) begin
            crc_d = '0;
        end else if (step) begin
            crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end else if (drain) begin
            crc_d = {crc_q[CRC_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign msb = crc_q[CRC_W-1];
endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx #(
    parameter int               IDX_W    = 6,
    parameter int               ARG_W    = 32,
    parameter int               CRC_W    = 7,
    parameter logic [CRC_W-1:0] CRC_POLY = 7'b0001001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             start,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [ARG_W-1:0] cmd_arg,
    output logic             busy,
    output logic             done,
    output logic             cmd_out,
    output logic             cmd_oe
);
    import sd_cmd_pkg::*;

    localparam int HEAD_W = 2 + IDX_W + ARG_W;
    localparam int CNT_W  = $clog2(HEAD_W + 1);

    typedef struct packed {
        tx_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             out;
        logic             oe;
        logic             busy;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic sh_load, sh_shift, sh_msb;
    logic crc_clr, crc_step, crc_drain, crc_msb;

    sd_cmd_shreg #(.W(HEAD_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val ({2'b01, cmd_idx, cmd_arg}),
        .shift    (sh_shift),
        .msb      (sh_msb)
    );

    sd_crc7_ser #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clr),
        .step  (crc_step),
        .din   (sh_msb),
        .drain (crc_drain),
        .msb   (crc_msb)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        sh_load    = 1'b0;
        sh_shift   = 1'b0;
        crc_clr    = 1'b0;
        crc_step   = 1'b0;
        crc_drain  = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    sh_load     = 1'b1;
                    crc_clr     = 1'b1;
                    ctl_d.busy  = 1'b1;
                    ctl_d.cnt   = '0;
                    ctl_d.state = ST_HEAD;
                end
            end
            ST_HEAD: begin
                if (bit_en) begin
                    ctl_d.out = sh_msb;
                    ctl_d.oe  = 1'b1;
                    sh_shift  = 1'b1;
                    crc_step  = 1'b1;
                    if (ctl_q.cnt == CNT_W'(HEAD_W - 1)) begin
                        ctl_d.cnt   = '0;
                        ctl_d.state = ST_CRC;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
            end
            ST_CRC: begin
                if (bit_en) begin
                    ctl_d.out = crc_msb;
                    crc_drain = 1'b1;
                    if (ctl_q.cnt == CNT_W'(CRC_W - 1)) begin
                        ctl_d.cnt   = '0;
                        ctl_d.state = ST_STOP;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (bit_en) begin
                    ctl_d.out   = 1'b1;
                    ctl_d.state = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (bit_en) begin
                    ctl_d.out   = 1'b1;
                    ctl_d.oe    = 1'b0;
                    ctl_d.busy  = 1'b0;
                    ctl_d.done  = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.cnt   <= '0;
            ctl_q.out   <= 1'b1;
            ctl_q.oe    <= 1'b0;
            ctl_q.busy  <= 1'b0;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy    = ctl_q.busy;
    assign done    = ctl_q.done;
    assign cmd_out = ctl_q.out;
    assign cmd_oe  = ctl_q.oe;
endmodule

// File: rtl/sd_cmd_tx_chk.sv
module sd_cmd_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic start,
    input logic busy,
    input logic done,
    input logic cmd_out,
    input logic cmd_oe
);
    // R6: done lasts one cycle
    p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: release and done coincide
    p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !cmd_oe));

    // R6: done only after a strobed edge
    p_done_strobed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bit_en));

    // R5: line released while not busy
    p_idle_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmd_oe && cmd_out));

    // R3: no change without strobe
    p_hold_no_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(cmd_out) && $stable(cmd_oe)));

    // R4: accepted start raises busy
    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R4: busy only drops together with done
    p_busy_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R1: first driven bit is the 0 start bit
    p_first_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out);
endmodule

bind sd_cmd_tx sd_cmd_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .cmd_out (cmd_out),
    .cmd_oe  (cmd_oe)
);

// File: tb/sd_cmd_tx_bench.sv
module sd_cmd_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;
    localparam int NVEC       = 6;
    // {use_const, idx, arg, crc, strobe spacing}
    localparam logic [49:0] VEC [NVEC] = '{
        {1'b1, 6'd0,  32'h0000_0000, 7'b1001010, 4'd3},
        {1'b1, 6'd8,  32'h0000_01AA, 7'b1000011, 4'd3},
        {1'b1, 6'd55, 32'h0000_0000, 7'b0110010, 4'd1},
        {1'b0, 6'd63, 32'hFFFF_FFFF, 7'b0000000, 4'd5},
        {1'b0, 6'd17, 32'hA5A5_5A5A, 7'b0000000, 4'd3},
        {1'b1, 6'd8,  32'h0000_01AA, 7'b1000011, 4'd1}
    };

    logic clk = 0, rst_n = 0, bit_en = 0, start = 0;
    logic [5:0]  cmd_idx = '0;
    logic [31:0] cmd_arg = '0;
    logic busy, done, cmd_out, cmd_oe;
    int checks = 0, errs = 0, en_div = 3, ph = 0;

    sd_cmd_tx u_sd_cmd_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
        .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .busy(busy), .done(done),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            if (en_div == 0) begin
                bit_en = 1'b0;
            end else begin
                ph = (ph + 1) % en_div;
                bit_en = (ph == 0);
            end
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(logic [39:0] bits);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic fb = c[6] ^ bits[i];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'b0001001;
        end
        return c;
    endfunction

    task automatic send(input logic [5:0] idx, input logic [31:0] arg,
                        input logic [6:0] exp_crc, input bit mid_start);
        logic [47:0] got = '0, exp;
        int n = 0, guard = 0, bad_oe = 0, bad_hold = 0, bad_pre = 0, early_done = 0;
        logic en_prev, last_out = 1'b1, last_oe = 1'b0;
        exp = {2'b01, idx, arg, exp_crc, 1'b1};
        @(negedge clk); #1;
        start = 1'b1; cmd_idx = idx; cmd_arg = arg;
        @(negedge clk); #1;
        start = 1'b0;
        chk("R4", "busy after start", busy, 1);
        en_prev = bit_en;
        while (n < 49 && guard < 2000) begin
            guard++;
            @(negedge clk); #1;
            if (start) start = 1'b0;
            if (en_prev) begin
                if (n < 48) begin
                    got[47-n] = cmd_out;
                    if (!cmd_oe) bad_oe++;
                    if (done) early_done++;
                end else begin
                    chk("R6", "oe at release", cmd_oe, 0);
                    chk("R6", "done at release", done, 1);
                    chk("R6", "busy at release", busy, 0);
                    chk("R5", "idle level at release", cmd_out, 1);
                end
                n++;
            end else begin
                if (cmd_out !== last_out || cmd_oe !== last_oe) bad_hold++;
                if (n == 0 && (cmd_oe || !cmd_out || !busy)) bad_pre++;
            end
            last_out = cmd_out; last_oe = cmd_oe;
            if (mid_start && n == 10) begin
                start = 1'b1; cmd_idx = ~idx; cmd_arg = ~arg;
            end
            en_prev = bit_en;
        end
        chk("R1", "frame bits", got, exp);
        chk("R2", "crc field", got[7:1], exp_crc);
        chk("R5", "oe low during frame count", bad_oe, 0);
        chk("R3", "changes without strobe", bad_hold, 0);
        chk("R8", "line driven before first strobe", bad_pre, 0);
        chk("R6", "early done count", early_done, 0);
        @(negedge clk); #1;
        chk("R6", "done one cycle", done, 0);
        repeat (4 * (en_div + 1)) @(negedge clk);
        #1;
        chk("R4", "no relaunch busy", busy, 0);
        chk("R4", "no relaunch oe", cmd_oe, 0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R7", "reset out", cmd_out, 1);
        chk("R7", "reset oe", cmd_oe, 0);
        chk("R7", "reset busy", busy, 0);
        chk("R7", "reset done", done, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            logic [49:0] e = VEC[v];
            logic [6:0]  c;
            en_div = int'(e[3:0]);
            c = e[49] ? e[10:4] : ref_crc({2'b01, e[48:43], e[42:11]});
            send(e[48:43], e[42:11], c, 1'b0);
        end

        // R4: start while busy is ignored
        en_div = 3;
        send(6'd8, 32'h0000_01AA, 7'b1000011, 1'b1);

        // R8: strobe held off after start
        en_div = 0;
        @(negedge clk); #1;
        start = 1'b1; cmd_idx = 6'd55; cmd_arg = '0;
        @(negedge clk); #1;
        start = 1'b0;
        repeat (10) @(negedge clk);
        #1;
        chk("R8", "busy while waiting", busy, 1);
        chk("R8", "oe while waiting", cmd_oe, 0);
        chk("R8", "out while waiting", cmd_out, 1);

        // R7: reset mid frame
        en_div = 2;
        repeat (12) @(negedge clk);
        #1;
        chk("R5", "driving mid frame", cmd_oe, 1);
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R7", "mid reset out", cmd_out, 1);
        chk("R7", "mid reset oe", cmd_oe, 0);
        chk("R7", "mid reset busy", busy, 0);
        rst_n = 1'b1;

        // frame after reset starts clean
        en_div = 1;
        send(6'd0, 32'h0, 7'b1001010, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule